// File: doc/BRIEF.md
# I2C Master Burst Receive Engine

This block is the receive side of an I2C master. A single write of the byte count starts a burst of up to 32 bytes. The received bytes are packed into a word-organised buffer that the surrounding register logic can read in parallel. The bus timing comes from a fixed quarter-bit interval. SCL is driven as a push-pull output. SDA is open drain: the block pulls it low while `sda_oe_o` is high.

In addressed mode the engine runs the whole addressing sequence in hardware before it reads:
- a START;
- the target write-address byte, plus any further target-address bytes that are marked valid;
- up to three register-address bytes, each enabled by its own valid flag;
- a repeated START, then the read address.

In plain mode it skips all of that and clocks data straight away. This lets software chain bursts into one long read, because the bus is left with SCL held low after each burst. A per-burst control input picks whether the final byte is answered with ACK (more bursts follow) or NAK (the real end of the read). A NAK from the target on any address byte stops the burst and raises a NAK flag instead of the completion flag.

Top module: `i2cb_burst_rx`

## Requirements
- R1: After reset, `scl_o` is 1, `sda_oe_o` is 0, `busy_o`, `done_o` and `nak_o` are 0, and every bit of `rx_words_o` is 0.
- R2: With `addr_mode_i`=1 the engine sends, in this order, each of the following:
  - a START;
  - each target byte k (bits 8k+7:8k of `tgt_addr_i`) whose valid bit 24+k is set, with byte 0 sent with its bit 0 forced to 0;
  - each register byte n (bits 8n+7:8n of `reg_addr_i`) whose valid bit 24+n is set, in rising k and n;
  - a repeated START;
  - the byte `tgt_addr_i[7:0]` with bit 0 forced to 1.
- R3: Each byte is sent MSB first. SDA changes only while SCL is low, and it is sampled while SCL is high. A START or repeated START is SDA falling while SCL is high, and SDA is never released while SCL stays high.
- R4: The master answers every received byte with ACK (SDA low in the ninth clock), except the last byte of a burst. That byte gets NAK (SDA released) when `ack_last_i`=0 and ACK when `ack_last_i`=1.
- R5: Received byte n of a burst (counted from 0 in every burst) is written to word n/4 of the buffer at bits 8*(n%4)+7:8*(n%4), that is `rx_words_o[8n+7:8n]`. Buffer bytes that the burst does not reach keep their old value.
- R6: `done_o` rises when the last byte of the burst has been received, and `busy_o` falls at the same time. `done_o` stays set until the next accepted count write clears it, and it is never 1 while `busy_o` is 1.
- R7: With `addr_mode_i`=0 no START and no address byte is sent. The first clock pulse after the count write already carries received data.
- R8: A target NAK (SDA high in the ninth clock) on any address byte sets `nak_o`, ends the burst with `done_o` left at 0, and leaves SCL low with no further pulses.
- R9: A count above 32 is clamped to 32 bytes. A count of 0 in plain mode sets `done_o` on the next cycle with no SCL pulse. A count of 0 in addressed mode runs the address phases only.
- R10: A count write (`rx_cnt_we_i`) while `busy_o` is 1 has no effect on the running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_mode_i | input | 1 | 1 = run the address phases before reading, 0 = plain read |
| tgt_addr_i | input | 27 | Target address bytes [23:0], valid bits [26:24] |
| reg_addr_i | input | 27 | Register address bytes [23:0], valid bits [26:24] |
| ack_last_i | input | 1 | 1 = ACK the final byte of the burst, 0 = NAK it |
| rx_cnt_i | input | 6 | Number of bytes to read |
| rx_cnt_we_i | input | 1 | Count write strobe; starts a burst when idle |
| sda_i | input | 1 | SDA line level |
| scl_o | output | 1 | SCL drive |
| sda_oe_o | output | 1 | 1 = pull SDA low |
| busy_o | output | 1 | Burst in progress |
| done_o | output | 1 | Burst receive finished |
| nak_o | output | 1 | Target NAK seen on an address byte |
| rx_words_o | output | 256 | Receive buffer, word w at bits 32w+31:32w |

## Verification
The bench builds the engine with a quarter-bit interval of 2 clock cycles and the default 32-byte buffer. This keeps each bit at 8 cycles, so a full clamped 32-byte burst fits easily. The bench runs it next to short addressed bursts, chained plain bursts, an address NAK and both zero-count forms. With the short interval, the whole buffer (all eight words) is filled and compared in one run. A count write is also injected in the middle of the long burst, so the running burst can be checked for interference.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;

    typedef enum logic [1:0] {
        S_IDLE,
        S_START,
        S_XFER
    } state_e;

    typedef enum logic [1:0] {
        K_SLOT,
        K_RDADDR,
        K_DATA
    } kind_e;

    localparam int unsigned SLOTS = 6;

    // address slots 0..2 are target bytes, 3..5 register bytes
    function automatic logic [7:0] slot_byte(input logic [26:0] tgt,
                                             input logic [26:0] rga,
                                             input logic [2:0]  s);
        logic [7:0] b;
        case (s)
            3'd0:    b = {tgt[7:1], 1'b0};
            3'd1:    b = tgt[15:8];
            3'd2:    b = tgt[23:16];
            3'd3:    b = rga[7:0];
            3'd4:    b = rga[15:8];
            default: b = rga[23:16];
        endcase
        return b;
    endfunction

    // first valid slot at or above 'from'; bit 3 of result = found
    function automatic logic [3:0] next_slot(input logic [5:0] vld,
                                             input logic [2:0] from);
        logic [3:0] r;
        r = 4'd0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (vld[i] && (i >= int'(from))) begin
                r = {1'b1, 3'(i)};
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/i2cb_qtick.sv
module i2cb_qtick #(
    parameter int unsigned QTR_CYCLES = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int unsigned CW = (QTR_CYCLES > 1) ? $clog2(QTR_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(QTR_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!en_i) begin
            cnt_d = '0;
        end else if (cnt_q == LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign tick_o = en_i && (cnt_q == LAST);

endmodule

// File: rtl/i2cb_rxbuf.sv
module i2cb_rxbuf #(
    parameter int unsigned MAX_BYTES = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en_i,
    input  logic [$clog2(MAX_BYTES)-1:0] wr_idx_i,
    input  logic [7:0]                 wr_byte_i,
    output logic [MAX_BYTES*8-1:0]     words_o
);
    localparam int unsigned WORDS = MAX_BYTES / 4;
    localparam int unsigned IDX_W = $clog2(MAX_BYTES);

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        for (genvar l = 0; l < 4; l++) begin : g_lane
            localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(w * 4 + l);
            logic [7:0] lane_d, lane_q;

            always_comb begin
                lane_d = lane_q;
                if (wr_en_i && (wr_idx_i == MY_IDX)) begin
                    lane_d = wr_byte_i;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    lane_q <= '0;
                end else begin
                    lane_q <= lane_d;
                end
            end

            assign words_o[w*32 + l*8 +: 8] = lane_q;
        end
    end

endmodule

// File: rtl/i2cb_seq.sv
module i2cb_seq
    import i2cb_pkg::*;
#(
    parameter int unsigned MAX_BYTES = 32,
    parameter int unsigned CNT_W     = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         tick_i,
    input  logic                         go_i,
    input  logic                         addr_mode_i,
    input  logic [26:0]                  tgt_addr_i,
    input  logic [26:0]                  reg_addr_i,
    input  logic                         ack_last_i,
    input  logic [CNT_W-1:0]             cnt_i,
    input  logic                         sda_i,
    output logic                         scl_o,
    output logic                         sda_oe_o,
    output logic                         busy_o,
    output logic                         done_o,
    output logic                         nak_o,
    output logic                         wr_en_o,
    output logic [$clog2(MAX_BYTES)-1:0] wr_idx_o,
    output logic [7:0]                   wr_byte_o
);
    localparam int unsigned IDX_W = $clog2(MAX_BYTES);
    localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(MAX_BYTES);

    typedef struct packed {
        state_e           st;
        kind_e            kind;
        logic [1:0]       ph;
        logic [3:0]       bitn;
        logic [7:0]       sh;
        logic [2:0]       slot;
        logic             rep;
        logic             nakseen;
        logic [CNT_W-1:0] total;
        logic [CNT_W-1:0] idx;
        logic             ackl;
        logic [26:0]      tgt;
        logic [26:0]      rga;
        logic             scl;
        logic             sda_oe;
        logic             done;
        logic             nak;
        logic             wr_en;
        logic [IDX_W-1:0] wr_idx;
        logic [7:0]       wr_byte;
    } seq_t;

    seq_t d, q;

    // SDA pull for the current bit slot
    function automatic logic bit_drive(input kind_e k, input logic [3:0] b,
                                       input logic [7:0] s, input logic last,
                                       input logic ackl);
        if (k == K_DATA) begin
            return (b == 4'd8) ? (!last || ackl) : 1'b0;
        end
        return (b == 4'd8) ? 1'b0 : !s[7];
    endfunction

    logic       last_byte;
    logic [5:0] slot_vld;
    logic [3:0] first_hit;
    logic [3:0] next_hit;

    assign last_byte = (q.idx + 1'b1) == q.total;
    assign slot_vld  = {q.rga[26:24], q.tgt[26:24]};
    assign first_hit = next_slot(slot_vld, 3'd0);
    assign next_hit  = next_slot(slot_vld, q.slot + 3'd1);

    always_comb begin
        d = q;
        d.wr_en = 1'b0;
        case (q.st)
            S_IDLE: begin
                if (go_i) begin
                    d.done  = 1'b0;
                    d.nak   = 1'b0;
                    d.tgt   = tgt_addr_i;
                    d.rga   = reg_addr_i;
                    d.ackl  = ack_last_i;
                    d.total = (cnt_i > MAX_CNT) ? MAX_CNT : cnt_i;
                    d.idx   = '0;
                    d.ph    = 2'd0;
                    d.bitn  = 4'd0;
                    if (addr_mode_i) begin
                        d.st     = S_START;
                        d.rep    = 1'b0;
                        d.scl    = 1'b0;
                        d.sda_oe = 1'b0;
                    end else if (cnt_i == '0) begin
                        d.done = 1'b1;
                    end else begin
                        d.st     = S_XFER;
                        d.kind   = K_DATA;
                        d.sh     = 8'h00;
                        d.scl    = 1'b0;
                        d.sda_oe = 1'b0;
                    end
                end
            end

            S_START: begin
                if (tick_i) begin
                    d.ph = q.ph + 2'd1;
                    case (q.ph)
                        2'd0: d.scl = 1'b1;
                        2'd1: d.sda_oe = 1'b1;
                        2'd2: d.scl = 1'b0;
                        default: begin
                            d.st   = S_XFER;
                            d.bitn = 4'd0;
                            if (q.rep || !first_hit[3]) begin
                                d.kind = K_RDADDR;
                                d.sh   = {q.tgt[7:1], 1'b1};
                            end else begin
                                d.kind = K_SLOT;
                                d.slot = first_hit[2:0];
                                d.sh   = slot_byte(q.tgt, q.rga, first_hit[2:0]);
                            end
                            d.sda_oe = bit_drive(d.kind, 4'd0, d.sh, last_byte, q.ackl);
                        end
                    endcase
                end
            end

            S_XFER: begin
                if (tick_i) begin
                    d.ph = q.ph + 2'd1;
                    case (q.ph)
                        2'd0: d.scl = 1'b1;
                        2'd1: d.scl = 1'b1;
                        2'd2: begin
                            d.scl = 1'b0;
                            if (q.bitn != 4'd8) begin
                                if (q.kind == K_DATA) begin
                                    d.sh = {q.sh[6:0], sda_i};
                                end
                            end else if (q.kind != K_DATA) begin
                                d.nakseen = sda_i;
                            end
                        end
                        default: begin
                            if (q.bitn != 4'd8) begin
                                d.bitn = q.bitn + 4'd1;
                                if (q.kind != K_DATA) begin
                                    d.sh = {q.sh[6:0], 1'b0};
                                end
                                d.sda_oe = bit_drive(q.kind, d.bitn, d.sh, last_byte, q.ackl);
                            end else if (q.kind == K_DATA) begin
                                d.wr_en   = 1'b1;
                                d.wr_idx  = q.idx[IDX_W-1:0];
                                d.wr_byte = q.sh;
                                d.idx     = q.idx + 1'b1;
                                if (last_byte) begin
                                    d.st     = S_IDLE;
                                    d.done   = 1'b1;
                                    d.sda_oe = 1'b0;
                                end else begin
                                    d.bitn   = 4'd0;
                                    d.sh     = 8'h00;
                                    d.sda_oe = 1'b0;
                                end
                            end else if (q.nakseen) begin
                                d.st     = S_IDLE;
                                d.nak    = 1'b1;
                                d.sda_oe = 1'b0;
                            end else if (q.kind == K_SLOT) begin
                                if (next_hit[3]) begin
                                    d.slot   = next_hit[2:0];
                                    d.bitn   = 4'd0;
                                    d.sh     = slot_byte(q.tgt, q.rga, next_hit[2:0]);
                                    d.sda_oe = bit_drive(K_SLOT, 4'd0, d.sh, last_byte, q.ackl);
                                end else begin
                                    d.st     = S_START;
                                    d.rep    = 1'b1;
                                    d.sda_oe = 1'b0;
                                end
                            end else if (q.total == '0) begin
                                d.st     = S_IDLE;
                                d.done   = 1'b1;
                                d.sda_oe = 1'b0;
                            end else begin
                                d.kind   = K_DATA;
                                d.bitn   = 4'd0;
                                d.sh     = 8'h00;
                                d.sda_oe = 1'b0;
                            end
                        end
                    endcase
                end
            end

            default: d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q         <= '0;
            q.st      <= S_IDLE;
            q.kind    <= K_SLOT;
            q.scl     <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign scl_o     = q.scl;
    assign sda_oe_o  = q.sda_oe;
    assign busy_o    = (q.st != S_IDLE);
    assign done_o    = q.done;
    assign nak_o     = q.nak;
    assign wr_en_o   = q.wr_en;
    assign wr_idx_o  = q.wr_idx;
    assign wr_byte_o = q.wr_byte;

endmodule

// File: rtl/i2cb_burst_rx.sv
module i2cb_burst_rx #(
    parameter int unsigned MAX_BYTES  = 32,
    parameter int unsigned QTR_CYCLES = 125,
    parameter int unsigned CNT_W      = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   addr_mode_i,
    input  logic [26:0]            tgt_addr_i,
    input  logic [26:0]            reg_addr_i,
    input  logic                   ack_last_i,
    input  logic [CNT_W-1:0]       rx_cnt_i,
    input  logic                   rx_cnt_we_i,
    input  logic                   sda_i,
    output logic                   scl_o,
    output logic                   sda_oe_o,
    output logic                   busy_o,
    output logic                   done_o,
    output logic                   nak_o,
    output logic [MAX_BYTES*8-1:0] rx_words_o
);
    localparam int unsigned IDX_W = $clog2(MAX_BYTES);

    logic             tick;
    logic             busy;
    logic             go;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [7:0]       wr_byte;

    assign go = rx_cnt_we_i && !busy;

    i2cb_qtick #(.QTR_CYCLES(QTR_CYCLES)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (busy),
        .tick_o (tick)
    );

    i2cb_seq #(.MAX_BYTES(MAX_BYTES), .CNT_W(CNT_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .go_i        (go),
        .addr_mode_i (addr_mode_i),
        .tgt_addr_i  (tgt_addr_i),
        .reg_addr_i  (reg_addr_i),
        .ack_last_i  (ack_last_i),
        .cnt_i       (rx_cnt_i),
        .sda_i       (sda_i),
        .scl_o       (scl_o),
        .sda_oe_o    (sda_oe_o),
        .busy_o      (busy),
        .done_o      (done_o),
        .nak_o       (nak_o),
        .wr_en_o     (wr_en),
        .wr_idx_o    (wr_idx),
        .wr_byte_o   (wr_byte)
    );

    i2cb_rxbuf #(.MAX_BYTES(MAX_BYTES)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_byte_i (wr_byte),
        .words_o   (rx_words_o)
    );

    assign busy_o = busy;

endmodule

// File: rtl/i2cb_burst_rx_chk.sv
module i2cb_burst_rx_chk (
    input logic clk,
    input logic rst_n,
    input logic rx_cnt_we_i,
    input logic scl_o,
    input logic sda_oe_o,
    input logic busy_o,
    input logic done_o,
    input logic nak_o
);
    AST_NO_SDA_RELEASE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_o && $past(scl_o)) |-> !$fell(sda_oe_o)); // R3

    AST_DONE_NOT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !done_o); // R6

    AST_DONE_NAK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && nak_o)); // R8

    AST_NAK_ENDS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        nak_o |-> !busy_o); // R8

    AST_IDLE_SCL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !$past(busy_o)) |-> $stable(scl_o)); // R8

    AST_COUNT_WRITE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt_we_i && !busy_o) |=> (busy_o || done_o)); // R9

    AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_cnt_we_i && busy_o && !done_o) |=> !(done_o && nak_o)); // R10
endmodule

bind i2cb_burst_rx i2cb_burst_rx_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_cnt_we_i (rx_cnt_we_i),
    .scl_o       (scl_o),
    .sda_oe_o    (sda_oe_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .nak_o       (nak_o)
);

// File: tb/i2cb_burst_rx_test.sv
`timescale 1ns/1ps
module i2cb_burst_rx_test;
    localparam int MAXB = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic addr_mode = 1'b0;
    logic [26:0] tgt = '0;
    logic [26:0] rga = '0;
    logic ackl = 1'b0;
    logic [5:0] cnt = '0;
    logic cnt_we = 1'b0;
    logic tgt_low = 1'b0;
    logic scl, sda_oe, busy, done, nak;
    logic [MAXB*8-1:0] words;
    wire sda_bus = !(sda_oe || tgt_low);

    int checks = 0;
    int errors = 0;
    int scl_edges = 0;
    logic [7:0] exp_buf [MAXB];

    typedef struct {
        int         kind;   // 0 start, 1 master write, 2 master read
        logic [7:0] b;
        logic       nak;    // write: target NAKs; read: master must NAK
    } item_t;
    item_t q[$];

    i2cb_burst_rx #(.MAX_BYTES(MAXB), .QTR_CYCLES(2)) uut (
        .clk (clk), .rst_n (rst_n), .addr_mode_i (addr_mode),
        .tgt_addr_i (tgt), .reg_addr_i (rga), .ack_last_i (ackl),
        .rx_cnt_i (cnt), .rx_cnt_we_i (cnt_we), .sda_i (sda_bus),
        .scl_o (scl), .sda_oe_o (sda_oe), .busy_o (busy),
        .done_o (done), .nak_o (nak), .rx_words_o (words)
    );

    always #5 clk = ~clk;
    always @(posedge scl or negedge scl) scl_edges++;

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // monitor: plays the target and compares the bus against the queue
    initial begin
        item_t it;
        logic [7:0] got;
        forever begin
            while (q.size() == 0) @(negedge clk);
            it = q[0];
            if (it.kind == 0) begin
                @(posedge scl); #1;
                check(sda_bus == 1'b1, "R3 start high", sda_bus, 1);
                @(negedge scl); #1;
                check(sda_bus == 1'b0, "R3 start fall", sda_bus, 0);
            end else if (it.kind == 1) begin
                for (int i = 0; i < 8; i++) begin
                    @(posedge scl); #1;
                    got = {got[6:0], sda_bus};
                    @(negedge scl);
                end
                check(got == it.b, "R2 address byte", got, it.b);
                tgt_low = !it.nak;
                @(posedge scl);
                @(negedge scl);
                tgt_low = 1'b0;
            end else begin
                for (int i = 0; i < 8; i++) begin
                    tgt_low = !it.b[7-i];
                    @(posedge scl);
                    @(negedge scl);
                end
                tgt_low = 1'b0;
                @(posedge scl); #1;
                check(sda_bus == it.nak, "R4 master ack bit", sda_bus, it.nak);
                @(negedge scl);
            end
            void'(q.pop_front());
        end
    end

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    task automatic push(input int k, input logic [7:0] b, input logic n);
        item_t it;
        it.kind = k; it.b = b; it.nak = n;
        q.push_back(it);
    endtask

    task automatic push_data(input int n, input logic last_ack, input int seed);
        for (int i = 0; i < n; i++) begin
            logic [7:0] v;
            v = 8'((i * 7 + seed) ^ (seed << 3));
            exp_buf[i] = v;
            push(2, v, (i == n - 1) && !last_ack);
        end
    endtask

    task automatic kick(input logic m, input logic [26:0] t, input logic [26:0] r,
                        input logic [5:0] c, input logic a);
        @(negedge clk);
        addr_mode = m; tgt = t; rga = r; cnt = c; ackl = a; cnt_we = 1'b1;
        @(negedge clk);
        cnt_we = 1'b0;
    endtask

    task automatic wait_end();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic check_buf(input string req);
        for (int w = 0; w < MAXB / 4; w++) begin
            logic [31:0] e;
            e = {exp_buf[4*w+3], exp_buf[4*w+2], exp_buf[4*w+1], exp_buf[4*w]};
            check(words[32*w +: 32] == e, req, words[32*w +: 32], e);
        end
    endtask

    initial begin
        for (int i = 0; i < MAXB; i++) exp_buf[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(scl == 1'b1 && sda_oe == 1'b0, "R1 bus idle", {scl, sda_oe}, 2'b10);
        check(!busy && !done && !nak, "R1 flags", {busy, done, nak}, 0);
        check(words == '0, "R1 buffer", words[63:0], 0);

        // R2 R4 R5: addressed burst, 2 register bytes, final NAK
        push(0, 0, 0); push(1, 8'hA0, 0); push(1, 8'h12, 0); push(1, 8'h34, 0);
        push(0, 0, 0); push(1, 8'hA1, 0);
        push_data(5, 1'b0, 8'h5A);
        kick(1'b1, {3'b001, 16'h0, 8'hA1}, {3'b011, 8'h0, 8'h34, 8'h12}, 6'd5, 1'b0);
        check(busy == 1'b1 && done == 1'b0, "R6 busy during burst", {busy, done}, 2'b10);
        wait_end();
        check(done && !nak, "R6 done after burst", {done, nak}, 2'b10);
        check(q.size() == 0, "R2 sequence consumed", q.size(), 0);
        check_buf("R5 packing A");

        // R7: chained plain bursts, first ends with ACK
        push_data(3, 1'b1, 8'h11);
        kick(1'b0, '0, '0, 6'd3, 1'b1);
        wait_end();
        check(done && q.size() == 0, "R7 plain burst", {done, 8'(q.size())}, 9'h100);
        check_buf("R5 partial word keeps old bytes");
        push_data(2, 1'b0, 8'h44);
        kick(1'b0, '0, '0, 6'd2, 1'b0);
        wait_end();
        check(done && q.size() == 0, "R7 second plain burst", {done, 8'(q.size())}, 9'h100);
        check_buf("R5 packing chained");

        // R9 clamp, three target bytes, no register bytes; R10 write while busy
        push(0, 0, 0); push(1, 8'h3C, 0); push(1, 8'h55, 0); push(1, 8'h66, 0);
        push(0, 0, 0); push(1, 8'h3D, 0);
        push_data(32, 1'b1, 8'h03);
        kick(1'b1, {3'b111, 8'h66, 8'h55, 8'h3D}, '0, 6'd63, 1'b1);
        repeat (300) @(negedge clk);
        cnt = 6'd1; addr_mode = 1'b0; cnt_we = 1'b1;   // R10 ignored write
        @(negedge clk);
        cnt_we = 1'b0;
        check(busy == 1'b1, "R10 burst keeps running", busy, 1);
        wait_end();
        check(done && q.size() == 0, "R9 clamp to 32 bytes", {done, 8'(q.size())}, 9'h100);
        check_buf("R9 full buffer");

        // R8: target NAKs the register byte
        push(0, 0, 0); push(1, 8'h42, 0); push(1, 8'h77, 1);
        kick(1'b1, {3'b001, 16'h0, 8'h42}, {3'b001, 16'h0, 8'h77}, 6'd4, 1'b0);
        wait_end();
        check(nak && !done, "R8 nak flag", {nak, done}, 2'b10);
        scl_edges = 0;
        repeat (100) @(negedge clk);
        check(scl_edges == 0 && scl == 1'b0, "R8 no further clocks", scl_edges, 0);
        check(q.size() == 0, "R8 sequence consumed", q.size(), 0);
        check_buf("R8 buffer untouched");

        // R9: zero count, plain then addressed
        scl_edges = 0;
        kick(1'b0, '0, '0, 6'd0, 1'b0);
        check(done && !busy && !nak, "R9 zero plain done", {done, busy, nak}, 3'b100);
        repeat (40) @(negedge clk);
        check(scl_edges == 0, "R9 zero plain no clocks", scl_edges, 0);
        push(0, 0, 0); push(1, 8'h20, 0); push(0, 0, 0); push(1, 8'h21, 0);
        kick(1'b1, {3'b001, 16'h0, 8'h20}, '0, 6'd0, 1'b0);
        wait_end();
        check(done && q.size() == 0, "R9 zero addressed", {done, 8'(q.size())}, 9'h100);
        check_buf("R9 buffer unchanged");

        finish_run();
    end
endmodule